// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block turns one pulse-width command into two switch enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. Neither enable turns on at a fixed delay. Each waits for a comparator flag reporting that the opposite gate has actually discharged. The result is a dead time that follows the real gate behaviour of the power stage.

The sequencer also provides the following protections:
- Light-load diode emulation: a zero-crossing comparator can switch the low side off, and it stays off for the rest of the low interval.
- A forced-continuous select that turns diode emulation off.
- A hard minimum off time for the high side, to refresh the bootstrap supply.
- An over-temperature shutdown that disables the drivers and drops a power-good flag.

The pulse-width command, the zero-cross flag and both discharge flags pass through synchronizer chains. All decisions are taken in a single state register. The gate enables are decoded from that register.

Top module: `gd_sequencer`

## Requirements
- R1: After the command rises, the high-side enable stays low until the synchronized low-gate-discharged flag has been seen high. Each input change affects the outputs at the third rising clock edge after it.
- R2: After the command falls, the low-side enable stays low until the synchronized high-gate-discharged flag has been seen high.
- R3: The high-side and low-side enables are never high in the same cycle.
- R4: With forced-continuous low, a zero-cross during low-side conduction drops the low-side enable. The enable stays low until the command has risen and fallen again, even after zero-cross clears.
- R5: With forced-continuous high, zero-cross has no effect: the low side stays on for the whole low interval of the command.
- R6: Once the high-side enable falls, it stays low for exactly MIN_OFF cycles (default 16) at minimum. A rise of the command during that window waits and takes effect when the window ends, but only if the command is still high then.
- R7: At the first clock edge where the over-temperature input is high, both enables, the driver-enable output and power-good all go low. They stay low while the input stays high.
- R8: When over-temperature clears, power-good and driver-enable return at the next edge and switching resumes without any other action.
- R9: During reset both enables, power-good and driver-enable are low. Power-good and driver-enable rise at the first edge after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_i | input | 1 | Pulse-width command, 1 = high side should conduct |
| ccm_force_i | input | 1 | 1 = forced continuous conduction, zero-cross ignored |
| zc_i | input | 1 | Zero-cross comparator, 1 = inductor current about to reverse |
| lo_clear_i | input | 1 | 1 = low-side gate below its threshold |
| hi_clear_i | input | 1 | 1 = high-side gate-to-phase voltage below its threshold |
| ot_i | input | 1 | Over-temperature flag, hysteresis applied outside |
| hi_en_o | output | 1 | High-side switch enable |
| lo_en_o | output | 1 | Low-side switch enable |
| drv_en_o | output | 1 | Driver enable, 0 = both gates tri-stated |
| pgood_o | output | 1 | Power-good flag |

## Verification
The bench holds each discharge flag low and checks that the matching enable never fires. It then counts the exact edge at which the enable rises once the flag returns. A design with a fixed delay, or one that ignored the flag, would turn the switch on too early.

For the high-side off window, the bench measures the low time in whole cycles. It also sends a command pulse shorter than the window: a design that dropped the pending rise, or that applied it after the command had fallen, would show up here.

Zero-cross is raised and cleared again during one low interval. A design that did not latch the low side off would turn it back on.

Over-temperature is raised while the high side conducts, to catch a design that responds late or fails to recover.

// File: rtl/gd_pkg.sv
package gd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_HI,
      ST_HI_ON,
      ST_WAIT_LO,
      ST_LO_ON,
      ST_LO_HOLD,
      ST_TRIP
   } gd_state_e;

endpackage

// File: rtl/gd_sync.sv
module gd_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gd_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gd_offtimer.sv
module gd_offtimer #(
   parameter int MIN_OFF = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int CW = $clog2(MIN_OFF + 1);
   localparam logic [CW-1:0] RELOAD = CW'(MIN_OFF - 1);

   logic [CW-1:0] cnt;

   if (MIN_OFF < 1) begin : g_bad_min
      $error("gd_offtimer: MIN_OFF must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= RELOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/gd_fsm.sv
module gd_fsm
   import gd_pkg::*;
#(
   parameter int MIN_OFF   = 16,
   parameter bit DIODE_EMU = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_s,
   input  logic zc_s,
   input  logic lc_s,
   input  logic hc_s,
   input  logic ccm_i,
   input  logic ot_i,
   input  logic off_done,
   output logic off_load,
   output logic hi_en,
   output logic lo_en,
   output logic active
);
   localparam int RW = $clog2(MIN_OFF + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(MIN_OFF);

   gd_state_e state, nxt;
   logic      zc_cut;

   if (DIODE_EMU) begin : g_demu
      assign zc_cut = !ccm_i && zc_s;
   end else begin : g_ccm_only
      assign zc_cut = 1'b0;
   end

   always_comb begin
      nxt = state;
      if (ot_i) begin
         nxt = ST_TRIP;
      end else begin
         unique case (state)
            ST_IDLE:    nxt = pwm_s ? ST_WAIT_HI : ST_WAIT_LO;
            ST_WAIT_HI: if (!pwm_s)                nxt = ST_WAIT_LO;
                        else if (lc_s && off_done) nxt = ST_HI_ON;
            ST_HI_ON:   if (!pwm_s)                nxt = ST_WAIT_LO;
            ST_WAIT_LO: if (pwm_s)                 nxt = ST_WAIT_HI;
                        else if (hc_s)             nxt = ST_LO_ON;
            ST_LO_ON:   if (pwm_s)                 nxt = ST_WAIT_HI;
                        else if (zc_cut)           nxt = ST_LO_HOLD;
            ST_LO_HOLD: if (pwm_s)                 nxt = ST_WAIT_HI;
            ST_TRIP:                               nxt = ST_IDLE;
            default:                               nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         active <= 1'b0;
      end else begin
         state  <= nxt;
         active <= (nxt != ST_TRIP);
      end
   end

   assign off_load = (state == ST_HI_ON) && (nxt != ST_HI_ON);
   assign hi_en    = (state == ST_HI_ON);
   assign lo_en    = (state == ST_LO_ON);

   // Length of the current low run of the high-side enable, saturating
   logic [RW-1:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_run <= RUN_MAX;
      else if (hi_en)          low_run <= '0;
      else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
   end

   p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_en && lo_en));

   p_hi_waits_lc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_en) |-> $past(lc_s));

   p_lo_waits_hc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_en) |-> $past(hc_s));

   p_min_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_en) |-> (low_run >= RUN_MAX));

   p_ccm_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ccm_i && lo_en && !pwm_s && !ot_i) |=> lo_en);

   p_ot_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ot_i |=> (!hi_en && !lo_en && !active));
endmodule

// File: rtl/gd_sequencer.sv
module gd_sequencer #(
   parameter int MIN_OFF     = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit DIODE_EMU   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_i,
   input  logic ccm_force_i,
   input  logic zc_i,
   input  logic lo_clear_i,
   input  logic hi_clear_i,
   input  logic ot_i,
   output logic hi_en_o,
   output logic lo_en_o,
   output logic drv_en_o,
   output logic pgood_o
);
   localparam int NSYNC = 4;

   logic [NSYNC-1:0] raw, synced;
   logic             off_load, off_done, active;

   assign raw = {pwm_i, zc_i, lo_clear_i, hi_clear_i};

   gd_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (synced)
   );

   gd_offtimer #(.MIN_OFF(MIN_OFF)) u_offtimer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (off_load),
      .done  (off_done)
   );

   gd_fsm #(.MIN_OFF(MIN_OFF), .DIODE_EMU(DIODE_EMU)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_s    (synced[3]),
      .zc_s     (synced[2]),
      .lc_s     (synced[1]),
      .hc_s     (synced[0]),
      .ccm_i    (ccm_force_i),
      .ot_i     (ot_i),
      .off_done (off_done),
      .off_load (off_load),
      .hi_en    (hi_en_o),
      .lo_en    (lo_en_o),
      .active   (active)
   );

   assign drv_en_o = active;
   assign pgood_o  = active;
endmodule

// File: tb/tb_gd_sequencer.sv
module tb_gd_sequencer;
   localparam int MIN_OFF = 16;

   logic clk = 1'b0;
   logic rst_n, pwm, ccm, zc, lc, hc, ot;
   logic hi, lo, drv, pg;
   int   total = 0, bad = 0;
   int   overlap = 0;
   bit   hung = 1'b0;

   always #4 clk = ~clk;

   gd_sequencer #(.MIN_OFF(MIN_OFF)) dut (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .ccm_force_i(ccm), .zc_i(zc),
      .lo_clear_i(lc), .hi_clear_i(hc), .ot_i(ot),
      .hi_en_o(hi), .lo_en_o(lo), .drv_en_o(drv), .pgood_o(pg)
   );

   always @(negedge clk) if (rst_n && hi && lo) overlap++;

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic t_reset_r9();
      chk("R9", "hi in reset", hi, 1'b0);
      chk("R9", "lo in reset", lo, 1'b0);
      chk("R9", "pgood in reset", pg, 1'b0);
      chk("R9", "drv in reset", drv, 1'b0);
      rst_n = 1'b1;
      tick(1);
      chk("R9", "pgood after first edge", pg, 1'b1);
      chk("R9", "drv after first edge", drv, 1'b1);
      tick(1);
      chk("R9", "lo before sync", lo, 1'b0);
      tick(1);
      chk("R9", "lo on third edge", lo, 1'b1);
   endtask

   task automatic t_lower_wait_r1();
      lc = 1'b0; pwm = 1'b1;
      tick(3);
      chk("R1", "lo off after rise", lo, 1'b0);
      chk("R1", "hi held by lc", hi, 1'b0);
      tick(3);
      chk("R1", "hi still held", hi, 1'b0);
      lc = 1'b1;
      tick(2);
      chk("R1", "hi before edge 3", hi, 1'b0);
      tick(1);
      chk("R1", "hi on edge 3", hi, 1'b1);
   endtask

   task automatic t_upper_wait_r2();
      hc = 1'b0; pwm = 1'b0;
      tick(3);
      chk("R2", "hi off after fall", hi, 1'b0);
      chk("R2", "lo held by hc", lo, 1'b0);
      tick(3);
      chk("R2", "lo still held", lo, 1'b0);
      hc = 1'b1;
      tick(2);
      chk("R2", "lo before edge 3", lo, 1'b0);
      tick(1);
      chk("R2", "lo on edge 3", lo, 1'b1);
   endtask

   task automatic t_ccm_r5();
      int drops = 0;
      ccm = 1'b1; zc = 1'b1;
      for (int i = 0; i < 10; i++) begin
         tick(1);
         if (!lo) drops++;
      end
      total++;
      if (drops != 0) begin
         bad++;
         $display("FAIL R5 lo dropped with ccm: actual=%0d expected=0", drops);
      end
      zc = 1'b0;
      tick(3);
   endtask

   task automatic t_zc_latch_r4();
      ccm = 1'b0;
      zc = 1'b1;
      tick(2);
      chk("R4", "lo before zc sync", lo, 1'b1);
      tick(1);
      chk("R4", "lo cut by zc", lo, 1'b0);
      zc = 1'b0;
      tick(5);
      chk("R4", "lo stays off after zc clears", lo, 1'b0);
      pwm = 1'b1;
      tick(4);
      chk("R4", "hi after next rise", hi, 1'b1);
      pwm = 1'b0;
      tick(4);
      chk("R4", "lo back after next fall", lo, 1'b1);
      ccm = 1'b1;
   endtask

   task automatic t_min_off_r6();
      int n;
      bit seen = 1'b0;
      tick(20);
      pwm = 1'b1;
      tick(4);
      chk("R6", "hi on", hi, 1'b1);
      tick(5);
      pwm = 1'b0;
      tick(3);
      chk("R6", "hi off after fall", hi, 1'b0);
      pwm = 1'b1;
      n = 1;
      while (!hi && n < 100) begin
         tick(1);
         n++;
      end
      total++;
      if (n - 1 != MIN_OFF) begin
         bad++;
         $display("FAIL R6 low time: actual=%0d expected=%0d", n - 1, MIN_OFF);
      end
      pwm = 1'b0;
      tick(3);
      chk("R6", "hi off before short pulse", hi, 1'b0);
      pwm = 1'b1;
      tick(4);
      pwm = 1'b0;
      for (int i = 0; i < 30; i++) begin
         tick(1);
         if (hi) seen = 1'b1;
      end
      chk("R6", "short pulse dropped", seen, 1'b0);
   endtask

   task automatic t_overtemp_r7_r8();
      pwm = 1'b1;
      tick(20);
      chk("R7", "hi on before trip", hi, 1'b1);
      ot = 1'b1;
      tick(1);
      chk("R7", "hi off on trip", hi, 1'b0);
      chk("R7", "lo off on trip", lo, 1'b0);
      chk("R7", "pgood low on trip", pg, 1'b0);
      chk("R7", "drv low on trip", drv, 1'b0);
      tick(5);
      chk("R7", "hi held off", hi, 1'b0);
      chk("R7", "pgood held low", pg, 1'b0);
      ot = 1'b0;
      tick(1);
      chk("R8", "pgood back", pg, 1'b1);
      chk("R8", "drv back", drv, 1'b1);
      tick(25);
      chk("R8", "hi resumes", hi, 1'b1);
   endtask

   initial begin
      #(8 * 20000);
      hung = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pwm = 1'b0; ccm = 1'b1; zc = 1'b0;
      lc = 1'b1; hc = 1'b1; ot = 1'b0;
      tick(3);
      t_reset_r9();
      t_lower_wait_r1();
      t_upper_wait_r2();
      t_ccm_r5();
      t_zc_latch_r4();
      t_min_off_r6();
      t_overtemp_r7_r8();
      total++;
      if (overlap != 0) begin
         bad++;
         $display("FAIL R3 overlap cycles: actual=%0d expected=0", overlap);
      end
      if (!hung) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule